// File: doc/BRIEF.md
# Bus Speed Mode and Receive Tune Control Register

This block is one 32-bit host control register for a card interface. It holds a three-bit bus speed mode and a six-bit receive sample-point tune value, and it drives the effective tune value and a decoded speed mode into the neighbouring PHY and datapath logic. Software writes the register and reads it back. Setting the update-request bit starts a tune update. The bit reads as one while the update is in progress and clears itself after a fixed number of cycles.

A timing erratum on the receive path means that one update request is not reliable. The effective tune output therefore changes only when a second request directly follows a first. The sample-point delay line covers only 43 positions, so stored values from 43 to 63 wrap back to the bottom of the range. A strobe-enable input can swap the two HS400 variants while the link runs, without a register write.

The update sequencer has four states. ST_IDLE moves to ST_FIRST on an accepted write with the request bit set (transition T_REQ1). ST_FIRST moves to ST_PRIMED when its latency count expires (T_PRIME). ST_PRIMED moves to ST_SECOND on another accepted request (T_REQ2), or back to ST_IDLE on an accepted write with the request bit clear (T_CANCEL). ST_SECOND moves to ST_IDLE when its count expires, and commits the tune value on that same edge (T_COMMIT).

Top module: `spdtune_ctrl`

## Requirements
- R1: After reset, rd_data, mode_out and tune_out are all zero.
- R2: A write with bit 15 clear stores bits 2:0 as the mode and bits 13:8 as the tune value. Readback returns those fields, and every other bit reads zero. tune_out does not change.
- R3: A write accepted with bit 15 set makes bit 15 of rd_data read one for exactly UPD_LAT cycles, after which it reads zero.
- R4: The first request of a pair leaves tune_out unchanged.
- R5: A request accepted while the block is primed sets tune_out to the stored tune value, taken modulo 43, on the edge where bit 15 clears.
- R6: A write with bit 15 clear, accepted while the block is primed, cancels the priming. The next request then counts as a first request.
- R7: Writes presented while bit 15 reads one are ignored entirely.
- R8: Stored tune values 43 to 63 become the value minus 43 on tune_out: 43 gives 0 and 63 gives 20. Values 0 to 42 pass unchanged.
- R9: mode_out equals the stored mode for the encodings 0 (SD), 2 (eMMC SDR), 3 (eMMC DDR), 4 (HS200), 5 (HS400) and 6 (HS400 enhanced strobe). The encodings 1 and 7 are stored and read back, but mode_out shows them as 0.
- R10: When strobe_en changes while no write is accepted, a mode of 5 becomes 6 if strobe_en is now 1, and a mode of 6 becomes 5 if strobe_en is now 0. Any other mode is not affected.
- R11: If a write is accepted on the same edge as a strobe_en change, the written mode wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data: mode 2:0, tune 13:8, update request 15 |
| strobe_en | input | 1 | Enhanced-strobe enable level |
| rd_data | output | 32 | Register readback; bit 15 reads one while an update is in progress |
| mode_out | output | 3 | Decoded speed mode |
| tune_out | output | 6 | Committed effective tune value (0 to 42) |

## Verification
The bench builds the block with its default UPD_LAT of 4. At that latency there is a busy window of several cycles, so a write can be placed inside it to show that it is ignored. It also allows the busy length to be counted exactly. The random mix of plain writes, requests and strobe flips reaches every sequencer transition, including cancellation from ST_PRIMED. The full tune range of 0 to 63 comes within reach, so both sides of the wrap at 43 are covered.

// File: rtl/spdtune_pkg.sv
package spdtune_pkg;

    // Field positions that software decodes
    localparam int MODE_LSB = 0;
    localparam int MODE_W   = 3;
    localparam int TUNE_LSB = 8;
    localparam int TUNE_W   = 6;
    localparam int UPD_BIT  = 15;

    typedef enum logic [MODE_W-1:0] {
        MD_SD       = 3'd0,
        MD_RSV1     = 3'd1,
        MD_MMC_SDR  = 3'd2,
        MD_MMC_DDR  = 3'd3,
        MD_HS200    = 3'd4,
        MD_HS400    = 3'd5,
        MD_HS400_ES = 3'd6,
        MD_RSV7     = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_PRIMED,
        ST_SECOND
    } upd_state_e;

endpackage

// File: rtl/spdtune_seq.sv
module spdtune_seq
    import spdtune_pkg::*;
#(
    parameter int UPD_LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic cancel,
    output logic busy,
    output logic commit
);
    localparam int CNT_W = (UPD_LAT > 1) ? $clog2(UPD_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(UPD_LAT - 1);

    upd_state_e state, state_nxt;
    logic [CNT_W-1:0] cnt;

    // Next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (req) state_nxt = ST_FIRST;            // T_REQ1
            ST_FIRST:  if (cnt == '0) state_nxt = ST_PRIMED;     // T_PRIME
            ST_PRIMED: begin
                if (req)         state_nxt = ST_SECOND;          // T_REQ2
                else if (cancel) state_nxt = ST_IDLE;            // T_CANCEL
            end
            ST_SECOND: if (cnt == '0) state_nxt = ST_IDLE;       // T_COMMIT
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // State register and latency counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            if (req && (state == ST_IDLE || state == ST_PRIMED))
                cnt <= CNT_LOAD;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy   = 1'b0;
        commit = 1'b0;
        unique case (state)
            ST_FIRST:  busy = 1'b1;
            ST_SECOND: begin
                busy   = 1'b1;
                commit = (cnt == '0);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spdtune_fields.sv
module spdtune_fields
    import spdtune_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              strobe_en,
    output logic [MODE_W-1:0] mode_raw,
    output logic [TUNE_W-1:0] tune_raw,
    output logic [MODE_W-1:0] mode_dec
);
    logic strobe_q;
    logic strobe_chg;

    assign strobe_chg = (strobe_en != strobe_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_raw <= '0;
            tune_raw <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe_en;
            if (wr_acc) begin
                mode_raw <= wr_data[MODE_LSB +: MODE_W];
                tune_raw <= wr_data[TUNE_LSB +: TUNE_W];
            end else if (strobe_chg) begin
                if (strobe_en && mode_raw == MD_HS400)
                    mode_raw <= MD_HS400_ES;
                else if (!strobe_en && mode_raw == MD_HS400_ES)
                    mode_raw <= MD_HS400;
            end
        end
    end

    always_comb begin
        unique case (mode_e'(mode_raw))
            MD_RSV1, MD_RSV7: mode_dec = MD_SD;
            default:          mode_dec = mode_raw;
        endcase
    end

endmodule

// File: rtl/spdtune_ctrl.sv
module spdtune_ctrl
    import spdtune_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int UPD_LAT   = 4,
    parameter int TUNE_SPAN = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              strobe_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [MODE_W-1:0] mode_out,
    output logic [TUNE_W-1:0] tune_out
);
    localparam logic [TUNE_W:0] SPAN = (TUNE_W + 1)'(TUNE_SPAN);

    logic              busy, commit, wr_acc, req, cancel;
    logic [MODE_W-1:0] mode_raw;
    logic [TUNE_W-1:0] tune_raw, tune_wrap;

    assign wr_acc = wr_en && !busy;
    assign req    = wr_acc && wr_data[UPD_BIT];
    assign cancel = wr_acc && !wr_data[UPD_BIT];

    spdtune_seq #(.UPD_LAT(UPD_LAT)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .cancel (cancel),
        .busy   (busy),
        .commit (commit)
    );

    spdtune_fields #(.DATA_W(DATA_W)) u_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_acc    (wr_acc),
        .wr_data   (wr_data),
        .strobe_en (strobe_en),
        .mode_raw  (mode_raw),
        .tune_raw  (tune_raw),
        .mode_dec  (mode_out)
    );

    // Fold the unusable top of the range back to the bottom
    always_comb begin
        if ({1'b0, tune_raw} >= SPAN)
            tune_wrap = TUNE_W'({1'b0, tune_raw} - SPAN);
        else
            tune_wrap = tune_raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      tune_out <= '0;
        else if (commit) tune_out <= tune_wrap;
    end

    always_comb begin
        rd_data                      = '0;
        rd_data[MODE_LSB +: MODE_W]  = mode_raw;
        rd_data[TUNE_LSB +: TUNE_W]  = tune_raw;
        rd_data[UPD_BIT]             = busy;
    end

endmodule

// File: rtl/spdtune_chk.sv
module spdtune_chk #(
    parameter int DATA_W    = 32,
    parameter int UPD_LAT   = 4,
    parameter int TUNE_SPAN = 43
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              strobe_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [2:0]        mode_out,
    input logic [5:0]        tune_out
);
    logic [15:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)          busy_run <= '0;
        else if (rd_data[15]) busy_run <= busy_run + 1'b1;
        else                 busy_run <= '0;
    end

    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 16'(UPD_LAT));

    p_tune_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tune_out) |-> $past(rd_data[15]));

    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15] |=> rd_data[13:8] == $past(rd_data[13:8]));

    p_tune_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tune_out) < TUNE_SPAN);

    p_mode_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_out != 3'd1 && mode_out != 3'd7);

    p_strobe_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strobe_en) && rd_data[2:0] == 3'd5 && !wr_en) |=> rd_data[2:0] == 3'd6);

    p_strobe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(strobe_en) && rd_data[2:0] == 3'd6 && !wr_en) |=> rd_data[2:0] == 3'd5);

endmodule

bind spdtune_ctrl spdtune_chk #(
    .DATA_W    (DATA_W),
    .UPD_LAT   (UPD_LAT),
    .TUNE_SPAN (TUNE_SPAN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .strobe_en (strobe_en),
    .rd_data   (rd_data),
    .mode_out  (mode_out),
    .tune_out  (tune_out)
);

// File: tb/spdtune_ctrl_bench.sv
module spdtune_ctrl_bench;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        strobe_en;
    logic [31:0] rd_data;
    logic [2:0]  mode_out;
    logic [5:0]  tune_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [2:0] e_mode;
    logic [5:0] e_tune;
    logic [5:0] e_eff;
    bit         primed;

    always #2 clk = ~clk;

    spdtune_ctrl #(.UPD_LAT(LAT)) u_spdtune_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .strobe_en(strobe_en), .rd_data(rd_data), .mode_out(mode_out),
        .tune_out(tune_out)
    );

    function automatic logic [5:0] wrap43(input logic [5:0] t);
        return (t >= 6'd43) ? t - 6'd43 : t;
    endfunction

    function automatic logic [2:0] dec(input logic [2:0] m);
        return (m == 3'd1 || m == 3'd7) ? 3'd0 : m;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        check({tag, " readback"}, rd_data, {18'd0, e_tune, 5'd0, e_mode});
        check({tag, " mode_out R9"}, 32'(mode_out), 32'(dec(e_mode)));
        check({tag, " tune_out"}, 32'(tune_out), 32'(e_eff));
    endtask

    task automatic plain_write(input logic [2:0] m, input logic [5:0] t, input logic [31:0] junk);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = (junk & ~32'h0000_BF07) | {18'd0, t, 5'd0, m};
        @(negedge clk);
        wr_en  = 1'b0;
        e_mode = m;
        e_tune = t;
        primed = 0;
        check_idle("R2 R6 plain write");
    endtask

    task automatic request(input logic [2:0] m, input logic [5:0] t, input logic [31:0] junk, input bit poke);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = (junk & ~32'h0000_BF07) | 32'h0000_8000 | {18'd0, t, 5'd0, m};
        @(negedge clk);
        wr_en  = 1'b0;
        e_mode = m;
        e_tune = t;
        check("R3 busy set", 32'(rd_data[15]), 32'd1);
        for (int k = 1; k < LAT; k++) begin
            if (poke && k == 1) begin
                wr_en   = 1'b1;
                wr_data = $urandom;
            end
            @(negedge clk);
            wr_en = 1'b0;
            check("R3 busy held", 32'(rd_data[15]), 32'd1);
            check("R7 fields kept", 32'(rd_data[13:0]), 32'({e_tune, 5'd0, e_mode}));
        end
        @(negedge clk);
        if (primed) begin
            e_eff  = wrap43(e_tune);
            primed = 0;
            check_idle("R5 R8 commit");
        end else begin
            primed = 1;
            check_idle("R4 first request");
        end
    endtask

    task automatic flip_strobe(input bit with_write, input logic [2:0] m);
        @(negedge clk);
        strobe_en = ~strobe_en;
        if (with_write) begin
            wr_en   = 1'b1;
            wr_data = {29'd0, m} | {18'd0, e_tune, 8'd0};
        end
        @(negedge clk);
        wr_en = 1'b0;
        if (with_write) begin
            e_mode = m;
            primed = 0;
            check_idle("R11 write wins");
        end else begin
            if (strobe_en && e_mode == 3'd5)       e_mode = 3'd6;
            else if (!strobe_en && e_mode == 3'd6) e_mode = 3'd5;
            check_idle("R10 strobe swap");
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; strobe_en = 1'b0;
        e_mode = '0; e_tune = '0; e_eff = '0; primed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 reset");

        // R8 wrap corners and R4/R5 pairing
        request(3'd4, 6'd43, 32'hFFFF_FFFF, 0);
        request(3'd4, 6'd43, 32'h0, 0);
        request(3'd4, 6'd63, 32'h0, 0);
        request(3'd4, 6'd63, 32'h0, 1);
        request(3'd2, 6'd42, 32'h0, 0);
        request(3'd2, 6'd42, 32'h0, 0);
        // R6 cancel between requests
        request(3'd3, 6'd10, 32'h0, 0);
        plain_write(3'd3, 6'd11, 32'h0);
        request(3'd3, 6'd12, 32'h0, 0);
        request(3'd3, 6'd13, 32'h0, 0);
        // R9 reserved encodings
        plain_write(3'd1, 6'd5, 32'hFFFF_FFFF);
        plain_write(3'd7, 6'd5, 32'h0);
        // R10 swaps and a non-HS400 mode
        plain_write(3'd5, 6'd0, 32'h0);
        flip_strobe(0, 3'd0);
        flip_strobe(0, 3'd0);
        plain_write(3'd4, 6'd0, 32'h0);
        flip_strobe(0, 3'd0);
        // R11
        plain_write(3'd5, 6'd0, 32'h0);
        flip_strobe(1, 3'd5);

        for (int i = 0; i < 400; i++) begin
            automatic int op = $urandom_range(0, 3);
            automatic logic [2:0] m = 3'($urandom);
            automatic logic [5:0] t = 6'($urandom);
            if ($urandom_range(0, 2) == 0) m = 3'($urandom_range(5, 6));
            unique case (op)
                0: plain_write(m, t, $urandom);
                1, 2: request(m, t, $urandom, $urandom_range(0, 1) == 1);
                default: flip_strobe($urandom_range(0, 3) == 0, m);
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule